// File: doc/BRIEF.md
# Hibernation Entry and Wake Controller

This controller decides when a chip may drop into a low-power hibernate state and when it must come back out. Software writes a control word that holds a hibernate request, one enable per wake source, a battery threshold select, a pin-retention mode and a retention hold bit. The controller accepts a request only if a timer or pin wake source is armed and the battery is above the selected threshold. While hibernating it asserts a power-off output. When an enabled wake source fires, it releases power again.

In retention mode the controller freezes the output level and output enable of every pad, except the four debug pads, at the moment of entry. The freeze lasts through hibernation and past wake, until software clears the hold bit. Each wake source also sets a sticky status bit whether or not its interrupt is masked. An interrupt line reports the OR of the unmasked status bits.

Asynchronous wake inputs pass through a two-flop synchronizer before the state machine looks at them. The battery comparison is already a synchronous digital value and is used directly.

Top module: `hib_ctrl`

## Requirements
- R1: A request (control bit 0 set to 1) is accepted only if control bit 1 (pin wake) or bit 2 (timer wake) is set; otherwise power stays on.
- R2: A request is dropped when `batt_level` is below the threshold 64 + 32*sel, where sel is control bits 11:10; a level equal to the threshold is accepted.
- R3: With control bit 8 (retention mode) set, an accepted request captures `pad_out` and `pad_oe` at the accepting edge, and the held pads keep those values. `pin_hold` is 1 on every held pad.
- R4: The four lowest pads (3:0) are never held: they always follow `pad_out`/`pad_oe`, and their `pin_hold` bits stay 0.
- R5: Retention is recorded in control bit 9. It stays set after wake until software writes that bit as 0. Software cannot set it by writing 1.
- R6: Only an enabled source ends hibernation. The enables are control bits 1..7, in this order: wake pin, timer match, external reset event, any GPIO wake input, any tamper input, oscillator failure, low battery. A disabled source keeps `pwr_off` high.
- R7: A timer match pulse and a low-battery condition (level below threshold) each end hibernation when enabled.
- R8: Status register (address 2) bits 0..6, in the same source order, latch any active source whatever the mask. Writing 1 to a status bit clears it.
- R9: `irq` is 1 exactly when some status bit and its mask bit (address 1, same bit order) are both 1.
- R10: A request bit is cleared by hardware one cycle after the state machine sees it, whether the request was accepted or dropped. A dropped request leaves `pwr_off` at 0.
- R11: After an accepted request, `pwr_off` rises on the second edge. After a wake input rises, `pwr_off` falls on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mask, 2 status (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Read data |
| wake_pin | input | 1 | External wake pin |
| ext_rst_evt | input | 1 | External reset event |
| gpio_wk | input | 4 | GPIO wake group |
| tamper | input | 4 | Tamper inputs |
| xosc_fail | input | 1 | Crystal oscillator failure |
| rtc_match | input | 1 | Timer match pulse |
| batt_level | input | 8 | Digitized battery level |
| pad_out | input | 16 | Pad output levels from the core |
| pad_oe | input | 16 | Pad output enables from the core |
| pad_out_q | output | 16 | Pad output levels after retention |
| pad_oe_q | output | 16 | Pad output enables after retention |
| pin_hold | output | 16 | Per-pad hold indication |
| pwr_off | output | 1 | Power gate: 1 while hibernating |
| irq | output | 1 | Masked interrupt |

## Verification
If the state machine stalls in the wrong state, `pwr_off` shows it within two or three edges of a request or a wake input. A lost or phantom hold bit shows on `pin_hold` and on the pads as soon as the core changes its outputs. A status bit that fails to latch or clear shows on the status read and on `irq` in the cycle after the write.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_HIB, ST_WAKE} hib_state_e;

  localparam int NSRC     = 7;
  localparam int SRC_PIN  = 0;
  localparam int SRC_RTC  = 1;
  localparam int SRC_RST  = 2;
  localparam int SRC_GPIO = 3;
  localparam int SRC_TAMP = 4;
  localparam int SRC_XOSC = 5;
  localparam int SRC_LBAT = 6;

  localparam int C_REQ    = 0;
  localparam int C_WEN_LO = 1;
  localparam int C_RET    = 8;
  localparam int C_HOLD   = 9;
  localparam int C_SEL_LO = 10;
  localparam int SEL_W    = 2;
  localparam int CTRL_W   = C_SEL_LO + SEL_W;

  localparam int BATT_W   = 8;
  localparam int THR_BASE = 64;
  localparam int THR_STEP = 32;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  function automatic logic [BATT_W-1:0] batt_thresh(input logic [SEL_W-1:0] sel);
    return BATT_W'(THR_BASE + THR_STEP * int'(sel));
  endfunction

  function automatic logic req_valid(input logic [NSRC-1:0] wen, input logic low);
    return (wen[SRC_PIN] | wen[SRC_RTC]) & ~low;
  endfunction
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_ok,
  input  logic       wake_hit,
  output hib_state_e st,
  output logic       req_clr,
  output logic       take
);
  hib_state_e st_d;

  assign req_clr = (st == ST_RUN) && req;
  assign take    = req_clr && req_ok;

  always_comb begin
    st_d = st;
    case (st)
      ST_RUN:   if (take) st_d = ST_ENTER;
      ST_ENTER: st_d = ST_HIB;
      ST_HIB:   if (wake_hit) st_d = ST_WAKE;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_RUN;
    else        st <= st_d;
  end

  a_r6_hib_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HIB && !wake_hit) |=> (st == ST_HIB));

  a_r11_enter_then_hib: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER) |=> (st == ST_HIB));

  a_r10_wake_returns_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE) |=> (st == ST_RUN));
endmodule

// File: rtl/hib_retain.sv
module hib_retain #(
  parameter int NPIN = 16,
  parameter int NDBG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            hold,
  input  logic [NPIN-1:0] pad_out,
  input  logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out_q,
  output logic [NPIN-1:0] pad_oe_q,
  output logic [NPIN-1:0] pin_hold
);
  localparam logic [NPIN-1:0] KEEP = ~NPIN'((1 << NDBG) - 1);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i < NDBG) begin : g_dbg
      assign pad_out_q[i] = pad_out[i];
      assign pad_oe_q[i]  = pad_oe[i];
      assign pin_hold[i]  = 1'b0;
    end else begin : g_held
      logic snap_o, snap_e;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          snap_o <= 1'b0;
          snap_e <= 1'b0;
        end else if (capture) begin
          snap_o <= pad_out[i];
          snap_e <= pad_oe[i];
        end
      end
      assign pad_out_q[i] = hold ? snap_o : pad_out[i];
      assign pad_oe_q[i]  = hold ? snap_e : pad_oe[i];
      assign pin_hold[i]  = hold;
    end
  end

  a_r3_frozen_pads: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> ($stable(pad_out_q & KEEP) && $stable(pad_oe_q & KEEP)));

  a_r4_dbg_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_hold & ~KEEP) == '0);
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPIN  = 16,
  parameter int NDBG  = 4,
  parameter int NGPIO = 4,
  parameter int NTAMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              wake_pin,
  input  logic              ext_rst_evt,
  input  logic [NGPIO-1:0]  gpio_wk,
  input  logic [NTAMP-1:0]  tamper,
  input  logic              xosc_fail,
  input  logic              rtc_match,
  input  logic [BATT_W-1:0] batt_level,
  input  logic [NPIN-1:0]   pad_out,
  input  logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out_q,
  output logic [NPIN-1:0]   pad_oe_q,
  output logic [NPIN-1:0]   pin_hold,
  output logic              pwr_off,
  output logic              irq
);
  localparam int SYNC_W = 4 + NGPIO + NTAMP;
  localparam int GP_LO  = 3;
  localparam int TP_LO  = GP_LO + NGPIO;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NSRC-1:0]   mask_q, raw_q, raw_d, wen, ev;
  logic [SYNC_W-1:0] sync_q;
  logic              batt_low, wake_hit, req_ok, req_clr, take;
  logic              wr_ctrl, wr_mask, wr_stat;
  hib_state_e        st;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DW-1:CTRL_W];

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_mask = wr_en && (wr_addr == A_MASK);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  assign wen      = ctrl_q[C_WEN_LO +: NSRC];
  assign batt_low = batt_level < batt_thresh(ctrl_q[C_SEL_LO +: SEL_W]);
  assign req_ok   = req_valid(wen, batt_low);

  hib_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({xosc_fail, tamper, gpio_wk, ext_rst_evt, rtc_match, wake_pin}),
    .q   (sync_q)
  );

  assign ev[SRC_PIN]  = sync_q[0];
  assign ev[SRC_RTC]  = sync_q[1];
  assign ev[SRC_RST]  = sync_q[2];
  assign ev[SRC_GPIO] = |sync_q[GP_LO +: NGPIO];
  assign ev[SRC_TAMP] = |sync_q[TP_LO +: NTAMP];
  assign ev[SRC_XOSC] = sync_q[SYNC_W-1];
  assign ev[SRC_LBAT] = batt_low;

  assign wake_hit = |(ev & wen);

  hib_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (ctrl_q[C_REQ]),
    .req_ok   (req_ok),
    .wake_hit (wake_hit),
    .st       (st),
    .req_clr  (req_clr),
    .take     (take)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (req_clr) ctrl_d[C_REQ] = 1'b0;
    if (take && ctrl_q[C_RET]) ctrl_d[C_HOLD] = 1'b1;
    if (wr_ctrl) begin
      ctrl_d         = wr_data[CTRL_W-1:0];
      ctrl_d[C_HOLD] = wr_data[C_HOLD] & ctrl_q[C_HOLD];
    end
  end

  assign raw_d = (raw_q & ~(wr_stat ? wr_data[NSRC-1:0] : '0)) | ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      raw_q  <= raw_d;
      if (wr_mask) mask_q <= wr_data[NSRC-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DW'(ctrl_q);
      A_MASK:  rd_data = DW'(mask_q);
      A_STAT:  rd_data = DW'(raw_q);
      default: rd_data = '0;
    endcase
  end

  assign irq     = |(raw_q & mask_q);
  assign pwr_off = (st == ST_HIB);

  hib_retain #(.NPIN(NPIN), .NDBG(NDBG)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (take),
    .hold      (ctrl_q[C_HOLD]),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_out_q (pad_out_q),
    .pad_oe_q  (pad_oe_q),
    .pin_hold  (pin_hold)
  );

  a_r1_needs_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && ctrl_q[C_REQ] && !(wen[SRC_PIN] | wen[SRC_RTC])) |=> (st == ST_RUN));

  a_r2_low_batt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && ctrl_q[C_REQ] && batt_low) |=> (st == ST_RUN));

  a_r10_req_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && ctrl_q[C_REQ] && !wr_ctrl) |=> !ctrl_q[C_REQ]);

  a_r5_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_HOLD] && !wr_ctrl) |=> ctrl_q[C_HOLD]);

  a_r8_pin_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ev[SRC_PIN] |=> raw_q[SRC_PIN]);

  a_r8_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: tb/tb_hib_ctrl.sv
module tb_hib_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wake_pin = 1'b0, ext_rst_evt = 1'b0, xosc_fail = 1'b0, rtc_match = 1'b0;
  logic [3:0]  gpio_wk = '0, tamper = '0;
  logic [7:0]  batt_level = 8'd200;
  logic [15:0] pad_out = '0, pad_oe = '0;
  logic [15:0] pad_out_q, pad_oe_q, pin_hold;
  logic        pwr_off, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] REQ = 32'h1, PIN = 32'h2, RTC = 32'h4, RET = 32'h100, HOLD = 32'h200;

  always #4 clk = ~clk;

  hib_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_pin(wake_pin), .ext_rst_evt(ext_rst_evt),
    .gpio_wk(gpio_wk), .tamper(tamper), .xosc_fail(xosc_fail), .rtc_match(rtc_match),
    .batt_level(batt_level), .pad_out(pad_out), .pad_oe(pad_oe), .pad_out_q(pad_out_q),
    .pad_oe_q(pad_oe_q), .pin_hold(pin_hold), .pwr_off(pwr_off), .irq(irq)
  );

  function automatic logic [31:0] sel_f(input int s);
    return 32'(s) << 10;
  endfunction

  function automatic int thr_of(input int s);
    return (s + 2) * 32;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      2: ext_rst_evt = v;
      3: gpio_wk[1] = v;
      4: tamper[3] = v;
      5: xosc_fail = v;
      default: batt_level = v ? 8'd10 : 8'd200;
    endcase
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("reset pwr_off", 32'(pwr_off), 0);
    chk("reset pin_hold", 32'(pin_hold), 0);
    chk("reset irq", 32'(irq), 0);
    rd(2'd0, v); chk("reset ctrl", v, 0);
    rd(2'd2, v); chk("reset status", v, 0);
  endtask

  task automatic t_drop_nowake();
    logic [31:0] v;
    wr(2'd0, REQ);
    tick(1);
    rd(2'd0, v); chk("R10 dropped req cleared", v & REQ, 0);
    tick(3);
    chk("R1 no wake source keeps power", 32'(pwr_off), 0);
  endtask

  task automatic t_battery();
    logic [31:0] v;
    batt_level = 8'(thr_of(2) - 1);
    wr(2'd0, REQ | PIN | sel_f(2));
    tick(3);
    chk("R2 below threshold dropped", 32'(pwr_off), 0);
    rd(2'd0, v); chk("R10 low batt req cleared", v & REQ, 0);
    batt_level = 8'(thr_of(2));
    wr(2'd0, REQ | PIN | sel_f(2));
    tick(1);
    chk("R11 not yet off after one edge", 32'(pwr_off), 0);
    rd(2'd0, v); chk("R10 accepted req cleared", v & REQ, 0);
    tick(1);
    chk("R2 equal threshold accepted", 32'(pwr_off), 1);
    wake_pin = 1'b1;
    tick(2);
    chk("R11 still off two edges after wake", 32'(pwr_off), 1);
    tick(1);
    chk("R11 on at third edge", 32'(pwr_off), 0);
    wake_pin = 1'b0;
    batt_level = 8'd200;
    tick(3);
    rd(2'd2, v); chk("R8 pin event latched unmasked", v & 32'h1, 32'h1);
    chk("R9 masked irq stays low", 32'(irq), 0);
  endtask

  task automatic t_retention();
    logic [31:0] v;
    pad_out = 16'hA5C3; pad_oe = 16'hF0F0;
    wr(2'd0, REQ | RTC | RET);
    tick(1);
    pad_out = 16'h5A3C; pad_oe = 16'h0F0F;
    tick(1);
    chk("R3 hibernating", 32'(pwr_off), 1);
    chk("R3 pin_hold", 32'(pin_hold), 32'hFFF0);
    chk("R3/R4 out held", 32'(pad_out_q), 32'hA5CC);
    chk("R3/R4 oe held", 32'(pad_oe_q), 32'hF0FF);
    rd(2'd0, v); chk("R5 hold bit set", v & HOLD, HOLD);
    rtc_match = 1'b1;
    tick(1);
    rtc_match = 1'b0;
    tick(3);
    chk("R7 timer match wakes", 32'(pwr_off), 0);
    tick(3);
    chk("R5 hold after wake", 32'(pin_hold), 32'hFFF0);
    chk("R5 out still frozen", 32'(pad_out_q), 32'hA5CC);
    wr(2'd0, HOLD);
    chk("R5 write 1 keeps hold", 32'(pin_hold), 32'hFFF0);
    wr(2'd0, 32'h0);
    chk("R5 release pin_hold", 32'(pin_hold), 0);
    chk("R5 out follows core", 32'(pad_out_q), 32'h5A3C);
    chk("R5 oe follows core", 32'(pad_oe_q), 32'h0F0F);
  endtask

  task automatic t_sources();
    for (int k = 2; k <= 6; k++) begin
      wr(2'd0, REQ | PIN | (32'h1 << (k + 1)));
      tick(2);
      chk(k == 6 ? "R7 entered" : "R6 entered", 32'(pwr_off), 1);
      set_src(k, 1'b1);
      tick(4);
      chk(k == 6 ? "R7 low battery wakes" : "R6 enabled source wakes", 32'(pwr_off), 0);
      set_src(k, 1'b0);
      tick(3);
    end
    wr(2'd0, REQ | PIN);
    tick(2);
    gpio_wk[2] = 1'b1;
    tamper[0] = 1'b1;
    tick(6);
    chk("R6 disabled sources ignored", 32'(pwr_off), 1);
    gpio_wk[2] = 1'b0; tamper[0] = 1'b0;
    wake_pin = 1'b1;
    tick(4);
    chk("R6 pin wake leaves", 32'(pwr_off), 0);
    wake_pin = 1'b0;
    tick(3);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(2'd2, 32'h7F);
    rd(2'd2, v); chk("R8 cleared all", v, 0);
    gpio_wk[1] = 1'b1;
    tick(1);
    gpio_wk[1] = 1'b0;
    tick(3);
    rd(2'd2, v); chk("R8 gpio latched", v, 32'h08);
    chk("R9 no mask no irq", 32'(irq), 0);
    wr(2'd1, 32'h08);
    chk("R9 mask raises irq", 32'(irq), 1);
    wr(2'd1, 32'h01);
    chk("R9 other mask bit no irq", 32'(irq), 0);
    wr(2'd1, 32'h08);
    wr(2'd2, 32'h01);
    rd(2'd2, v); chk("R8 w1c other bit keeps", v, 32'h08);
    wr(2'd2, 32'h08);
    rd(2'd2, v); chk("R8 w1c clears", v, 0);
    chk("R9 irq drops", 32'(irq), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_drop_nowake();
    t_battery();
    t_retention();
    t_sources();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule